// File: doc/BRIEF.md
# Seven-Operand Carry-Save Compressor

This block reduces seven unsigned W-bit operands to two vectors, a sum vector and a carry vector. The sum of the two vectors equals the sum of the seven operands. It is a row of identical bit-slices, one per result column. Each slice takes the seven operand bits of its column and reduces them with a small tree of full and half adders. It also accepts three transfer bits from lower columns: one from the column just below and two from the column two below. It returns one sum bit at its own weight, one carry bit at the next weight, and three transfers of its own: one towards the next column and two towards the column two higher.

Transfers are scheduled so that no chain of them can form across the word. The lower bit sent two columns up is derived from the seven operand bits alone. The bit sent one column up, and the upper bit sent two columns up, use only the operand bits and the operand-only bit arriving from two columns down. The bits arriving from one column down, and the upper bit from two columns down, enter only the last adder of the slice. The delay through the row therefore does not grow with W.

The result vectors are W+3 bits wide. That is enough to hold seven times the largest operand, so no transfer of value is lost off the top. Both vectors are registered once. A wider design feeds them to a single carry-propagate adder of W+3 bits.

Top module: `sev2_compressor`

## Requirements
- R1: An active-low asynchronous reset forces `sum_o` and `carry_o` to all zeros as soon as it is asserted, and holds them there while it stays low.
- R2: The operands sampled at a rising clock edge produce, right after that edge, outputs whose sum modulo 2^(W+3) equals the unsigned sum of the seven operands.
- R3: The result is exact up to the largest possible total. With every operand at 2^W-1, `sum_o + carry_o` equals 7*(2^W-1), and no transfer ever leaves the top column.
- R4: Bit 0 of `carry_o` is always zero, because the carry vector is offset by one column.
- R5: When no bit position has more than one operand bit set, `carry_o` is zero and `sum_o` equals the bitwise OR of the operands, zero-extended.
- R6: When all seven operands are zero, both outputs are zero one cycle later.
- R7: When the operands hold the same value across consecutive edges, both outputs keep the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; operands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 7 x W | Seven unsigned operands; element k is operand k |
| sum_o | output | W+3 | Registered sum vector, bit i has weight 2^i |
| carry_o | output | W+3 | Registered carry vector, bit i has weight 2^i, bit 0 always zero |

## Verification
The properties treat every operand as an unsigned number whose bits are defined at each rising edge. They compare outputs with inputs only after one full clock out of reset, so the registered results reflect sampled data and not the cleared state. The stimulus drives the operands on the falling edge and holds them steady through the next rising edge. It uses random words, hand-built patterns that give every column at most one set bit, all-zero words and all-ones words. The no-spill check relies on the fact that the total of seven W-bit unsigned operands always fits in W+3 bits. It therefore holds only while the operands are read as unsigned.

// File: rtl/sev2_pkg.sv
package sev2_pkg;

    // operands reduced by one slice
    localparam int NOPS = 7;
    // extra result columns above the operand width: ceil(log2(NOPS+1))
    localparam int SPAN = 3;

    // transfer bundle leaving a slice: one bit one column up, two bits two columns up
    typedef struct packed {
        logic       t1;
        logic [1:0] t2;
    } xfer_t;

endpackage

// File: rtl/sev2_fa.sv
module sev2_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end
endmodule

// File: rtl/sev2_ha.sv
module sev2_ha (
    input  logic a,
    input  logic b,
    output logic s,
    output logic co
);
    always_comb begin
        s  = a ^ b;
        co = a & b;
    end
endmodule

// File: rtl/sev2_slice.sv
module sev2_slice
    import sev2_pkg::*;
(
    input  logic [NOPS-1:0] a_i,     // seven operand bits of this column
    input  xfer_t           xfer_i,  // t1 from column-1, t2 from column-2
    output logic            s_o,     // weight 2^i
    output logic            c_o,     // weight 2^(i+1)
    output xfer_t           xfer_o
);
    // level 0: count the primaries into p0 (x1), p1 (x2), p2 (x4)
    logic s_a, c_a, s_b, c_b, c_c;
    logic p0, p1, p2;

    sev2_fa u_fa_a (.a(a_i[0]), .b(a_i[1]), .ci(a_i[2]), .s(s_a), .co(c_a));
    sev2_fa u_fa_b (.a(a_i[3]), .b(a_i[4]), .ci(a_i[5]), .s(s_b), .co(c_b));
    sev2_fa u_fa_c (.a(s_a),    .b(s_b),    .ci(a_i[6]), .s(p0),  .co(c_c));
    sev2_fa u_fa_d (.a(c_a),    .b(c_b),    .ci(c_c),    .s(p1),  .co(p2));

    // level 1: fold in the operand-only transfer from two columns below
    logic u0, u1;
    logic t1_n, t2_hi_n;

    sev2_ha u_ha_lo (.a(p0), .b(xfer_i.t2[0]), .s(u0),   .co(u1));
    sev2_ha u_ha_hi (.a(p1), .b(u1),           .s(t1_n), .co(t2_hi_n));

    // output level: the late transfers meet the residue here only
    sev2_fa u_fa_out (.a(u0), .b(xfer_i.t1), .ci(xfer_i.t2[1]), .s(s_o), .co(c_o));

    always_comb begin
        xfer_o.t1    = t1_n;
        xfer_o.t2[0] = p2;       // depends on primaries only
        xfer_o.t2[1] = t2_hi_n;  // primaries plus incoming t2[0]
    end
endmodule

// File: rtl/sev2_compressor.sv
module sev2_compressor
    import sev2_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NOPS-1:0][W-1:0]     op_i,
    output logic [W+SPAN-1:0]          sum_o,
    output logic [W+SPAN-1:0]          carry_o
);
    localparam int OW = W + SPAN;

    typedef struct packed {
        logic [OW-1:0] sum;
        logic [OW-1:0] carry;
    } res_t;

    res_t              res_d, res_q;
    logic [NOPS-1:0]   col [OW];
    xfer_t             xi  [OW];
    xfer_t             xo  [OW];
    logic [OW-1:0]     s_w;
    logic [OW-1:0]     c_w;

    for (genvar i = 0; i < OW; i++) begin : g_slice
        for (genvar k = 0; k < NOPS; k++) begin : g_col
            if (i < W) begin : g_live
                assign col[i][k] = op_i[k][i];
            end else begin : g_pad
                assign col[i][k] = 1'b0;
            end
        end

        if (i == 0) begin : g_in0
            assign xi[i] = '0;
        end else if (i == 1) begin : g_in1
            assign xi[i] = {xo[0].t1, 2'b00};
        end else begin : g_inn
            assign xi[i] = {xo[i-1].t1, xo[i-2].t2};
        end

        sev2_slice u_slice (
            .a_i    (col[i]),
            .xfer_i (xi[i]),
            .s_o    (s_w[i]),
            .c_o    (c_w[i]),
            .xfer_o (xo[i])
        );

        // R2: value is conserved across every slice
        a_r2_slice_balance: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(s_w[i]) + 2 * 32'(c_w[i]) + 2 * 32'(xo[i].t1)
             + 4 * 32'(xo[i].t2[0]) + 4 * 32'(xo[i].t2[1]))
            == (32'($countones(col[i])) + 32'(xi[i].t1)
                + 32'(xi[i].t2[0]) + 32'(xi[i].t2[1])));

        // R2: the low two-column transfer reflects the primaries alone
        a_r2_early_xfer: assert property (@(posedge clk) disable iff (!rst_n)
            xo[i].t2[0] == ($countones(col[i]) >= 4));
    end

    always_comb begin
        res_d.sum   = s_w;
        res_d.carry = {c_w[OW-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o   = res_q.sum;
    assign carry_o = res_q.carry;

    // ---------------- checks ----------------
    logic          primed_q;
    logic [OW-1:0] ref_total;
    logic [W-1:0]  seen;
    logic          overlap;
    logic          spill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    always_comb begin
        ref_total = '0;
        seen      = '0;
        overlap   = 1'b0;
        for (int k = 0; k < NOPS; k++) begin
            ref_total = ref_total + {{SPAN{1'b0}}, op_i[k]};
            overlap   = overlap | (|(seen & op_i[k]));
            seen      = seen | op_i[k];
        end
    end

    // bits that would leave the top column
    assign spill = c_w[OW-1] | xo[OW-1].t1 | (|xo[OW-1].t2) | (|xo[OW-2].t2);

    a_r2_total: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (OW'(res_q.sum + res_q.carry) == $past(ref_total)));

    a_r3_no_spill: assert property (@(posedge clk) disable iff (!rst_n)
        spill == 1'b0);

    a_r4_carry_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.carry[0] == 1'b0);

    a_r5_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(!overlap)) |-> (res_q.carry == '0));

    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(op_i == '0)) |-> (res_q == '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $stable(op_i)) |=> $stable(res_q));

endmodule

// File: tb/test_sev2_compressor.sv
`timescale 1ns/1ps
module test_sev2_compressor;
    localparam int W  = 16;
    localparam int NO = 7;
    localparam int OW = W + 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NO-1:0][W-1:0]  ops = '0;
    logic [OW-1:0]         sum_o, carry_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    sev2_compressor #(.W(W)) i_sev2_compressor (
        .clk(clk), .rst_n(rst_n), .op_i(ops), .sum_o(sum_o), .carry_o(carry_o)
    );

    typedef struct {
        logic [OW-1:0] total;
        logic [OW-1:0] orv;
        bit            disj;
        bit            hold;
        string         tag;
    } exp_t;

    exp_t sb[$];

    task automatic apply(input logic [NO-1:0][W-1:0] v, input string tag,
                         input bit disj, input bit hold);
        exp_t e;
        @(negedge clk);
        ops     = v;
        e.total = '0;
        e.orv   = '0;
        for (int k = 0; k < NO; k++) begin
            e.total = e.total + OW'(v[k]);
            e.orv   = e.orv | OW'(v[k]);
        end
        e.disj = disj;
        e.hold = hold;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // monitor: results of the operands driven before an edge are visible just after it
    initial begin
        exp_t e;
        logic [OW-1:0] got, last_s, last_c;
        last_s = '0;
        last_c = '0;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e   = sb.pop_front();
                got = OW'(sum_o + carry_o);
                nchk++;
                if (got !== e.total) begin
                    nfail++;
                    $display("FAIL %s: sum+carry=%0h expected %0h", e.tag, got, e.total);
                end
                nchk++;  // R4
                if (carry_o[0] !== 1'b0) begin
                    nfail++;
                    $display("FAIL R4: carry_o[0]=%0b expected 0", carry_o[0]);
                end
                if (e.disj) begin
                    nchk++;  // R5 / R6
                    if (carry_o !== '0 || sum_o !== e.orv) begin
                        nfail++;
                        $display("FAIL %s: sum=%0h carry=%0h expected sum=%0h carry=0",
                                 e.tag, sum_o, carry_o, e.orv);
                    end
                end
                if (e.hold) begin
                    nchk++;  // R7
                    if (sum_o !== last_s || carry_o !== last_c) begin
                        nfail++;
                        $display("FAIL R7: sum=%0h carry=%0h expected sum=%0h carry=%0h",
                                 sum_o, carry_o, last_s, last_c);
                    end
                end
                last_s = sum_o;
                last_c = carry_o;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [NO-1:0][W-1:0] v;
        logic [W-1:0] r;

        // R1: reset holds the outputs at zero even with busy inputs
        repeat (2) @(negedge clk);
        ops = '1;
        @(negedge clk);
        nchk++;
        if (sum_o !== '0 || carry_o !== '0) begin
            nfail++;
            $display("FAIL R1: sum=%0h carry=%0h expected 0 0", sum_o, carry_o);
        end
        ops   = '0;
        rst_n = 1'b1;

        // R6: all zero
        apply('0, "R6", 1'b1, 1'b0);

        // R3: largest total
        apply('1, "R3", 1'b0, 1'b0);
        // R7: same operands again
        apply('1, "R7", 1'b0, 1'b1);

        // R5: one operand at a time, others zero
        for (int k = 0; k < NO; k++) begin
            v = '0;
            v[k] = W'($urandom);
            apply(v, "R5", 1'b1, 1'b0);
        end

        // R5: columns owned by different operands
        for (int n = 0; n < 20; n++) begin
            r = W'($urandom);
            for (int k = 0; k < NO; k++) begin
                v[k] = '0;
                for (int b = 0; b < W; b++)
                    if (b % NO == k) v[k][b] = r[b];
            end
            apply(v, "R5", 1'b1, 1'b0);
        end

        // R2: random operands, with a held repeat now and then
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < NO; k++) v[k] = W'($urandom);
            apply(v, "R2", 1'b0, 1'b0);
            if (n % 50 == 0) apply(v, "R7", 1'b0, 1'b1);
        end

        // R2: identical operands with one high bit each
        for (int b = 0; b < W; b++) begin
            for (int k = 0; k < NO; k++) v[k] = W'(1) << b;
            apply(v, "R2", 1'b0, 1'b0);
        end

        // R6: back to zero after traffic
        apply('0, "R6", 1'b1, 1'b0);

        // drain
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);

        // R1: asynchronous reset in mid-run
        ops = '1;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        nchk++;
        if (sum_o !== '0 || carry_o !== '0) begin
            nfail++;
            $display("FAIL R1: sum=%0h carry=%0h expected 0 0", sum_o, carry_o);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule